// File: doc/BRIEF.md
# DMA Channel Start Control and Bus Bandwidth Throttle

This block is the control core of one DMA channel. It decides when the channel asks for the bus and when it must step off the bus for a moment so that other masters can get in. It does not move data. The data path, address generation and arbitration between channels sit elsewhere. The block takes register-style controls: a start strobe, an external-request enable, a 3-bit bandwidth code and a stop (done-write) strobe. It also takes a peripheral request, the initial byte count, and a bus-cycle-complete strobe that carries the byte size of the finished transfer.

A channel starts in one of two ways. With external requests disabled, the start strobe starts it. With them enabled, a peripheral request starts it. Once running, the byte count drops by the size of each completed transfer. When the count reaches zero, the channel finishes and raises a done flag. A stop strobe ends it early.

With a nonzero bandwidth code, the request line drops for one cycle whenever the remaining count lands exactly on a multiple of the selected block size. If transfers of 2 or 4 bytes step over that multiple without landing on it, nothing happens. The bandwidth code is read live, so changing it takes effect at once.

Top module: `dma_chan_throttle`

## Requirements
- R1: After a synchronous reset, `bus_req`, `chan_busy`, `chan_done` and `bcount` are all zero.
- R2: With `ctl_ext_en` low, an idle channel that sees `ctl_start` with a nonzero `cfg_count` has `chan_busy` and `bus_req` high and `bcount` equal to `cfg_count` one cycle later. `chan_done` is cleared at the same time.
- R3: With `ctl_ext_en` high, `ctl_start` is ignored. The channel stays idle and `bus_req` stays low until `periph_req` is seen, which then starts it as in R2.
- R4: Each cycle with `bus_ack` high on a busy channel lowers `bcount` by `xfer_bytes` (1, 2 or 4), saturating at zero. Without `bus_ack`, `bcount` holds.
- R5: When a completed transfer brings `bcount` to zero, the next cycle has `chan_done` high and `chan_busy` and `bus_req` low. No throttle gap comes first.
- R6: `ctl_done_wr` on a busy channel makes `chan_busy`, `bus_req` and `chan_done` low on the next cycle, with `bcount` frozen.
- R7: The bandwidth code selects the block size 2^(BW_BASE_LOG2+code-1) bytes for codes 1 to 7. With the default of 9, code 1 gives 512 bytes and code 7 gives 32768 bytes. Code 0 never throttles.
- R8: When a completed transfer leaves a nonzero `bcount` that is an exact multiple of the block size, `bus_req` is low for exactly the next cycle. It is high again on the cycle after that, unless the channel has been stopped.
- R9: When the count steps across a block multiple without landing on it, `bus_req` stays high.
- R10: A change of `ctl_bw_code` while the channel is running applies to the very next completed transfer.
- R11: `ctl_start` and `periph_req` on a busy channel are ignored, and `bcount` is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_start | input | 1 | Software start strobe |
| ctl_ext_en | input | 1 | 1: peripheral request starts the channel |
| ctl_bw_code | input | 3 | Bandwidth block-size code, 0 = no throttle |
| ctl_done_wr | input | 1 | Stop strobe, also clears the done flag |
| cfg_count | input | BC_W | Byte count loaded on start |
| periph_req | input | 1 | Peripheral DMA request |
| bus_ack | input | 1 | Bus transfer completed this cycle |
| xfer_bytes | input | XF_W | Byte size of the completed transfer |
| bus_req | output | 1 | Bus request |
| chan_busy | output | 1 | Channel active |
| chan_done | output | 1 | Count exhausted |
| bcount | output | BC_W | Remaining byte count |

## Verification
The throttle is swept over every bandwidth code with 1-, 2- and 4-byte transfers. Each sweep starts from counts just above two block multiples, at offsets of 3 and 4 bytes. Single-byte runs must land on every multiple and show one gap at each, which confirms the decoded block size for each code. Runs in 2- and 4-byte steps from an odd offset must step over the multiples without a gap, while 4-byte runs from an aligned offset must still land and throttle. Directed sequences cover the start sources, stop, start while busy, a code change in mid-run and saturation when the transfer is larger than the remaining count.

// File: rtl/dma_thr_pkg.sv
package dma_thr_pkg;

  localparam int BW_CODE_W = 3;
  localparam int BW_LEVELS = 1 << BW_CODE_W;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RUN  = 2'd1,
    CH_HOLD = 2'd2
  } ch_state_e;

endpackage

// File: rtl/dma_thr_counter.sv
module dma_thr_counter #(
  parameter int BC_W = 24,
  parameter int XF_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BC_W-1:0] load_val,
  input  logic            dec_en,
  input  logic [XF_W-1:0] dec_bytes,
  output logic [BC_W-1:0] cnt,
  output logic [BC_W-1:0] cnt_nxt,
  output logic            nxt_zero
);

  logic [BC_W-1:0] step;

  assign step = BC_W'(dec_bytes);

  always_comb begin
    cnt_nxt = cnt;
    if (dec_en) begin
      cnt_nxt = (cnt > step) ? (cnt - step) : '0;
    end
  end

  assign nxt_zero = (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec_en) begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/dma_thr_boundary.sv
module dma_thr_boundary
  import dma_thr_pkg::*;
#(
  parameter int BC_W        = 24,
  parameter int BASE_LOG2   = 9
) (
  input  logic [BW_CODE_W-1:0] code,
  input  logic [BC_W-1:0]      cnt_nxt,
  output logic                 landed
);

  logic [BC_W-1:0] mask_tbl [0:BW_LEVELS-1];

  assign mask_tbl[0] = '0;

  for (genvar g = 1; g < BW_LEVELS; g++) begin : g_mask
    localparam int SHIFT = BASE_LOG2 + g - 1;
    assign mask_tbl[g] = BC_W'((64'd1 << SHIFT) - 64'd1);
  end

  assign landed = (code != '0) && (cnt_nxt != '0) &&
                  ((cnt_nxt & mask_tbl[code]) == '0);

endmodule

// File: rtl/dma_thr_ctrl.sv
module dma_thr_ctrl
  import dma_thr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_evt,
  input  logic cfg_zero,
  input  logic done_wr,
  input  logic ack,
  input  logic nxt_zero,
  input  logic landed,
  output logic load,
  output logic dec_en,
  output logic bus_req,
  output logic busy,
  output logic done
);

  ch_state_e state;

  assign load    = (state == CH_IDLE) && start_evt;
  assign dec_en  = (state != CH_IDLE) && ack && !done_wr;
  assign bus_req = (state == CH_RUN);
  assign busy    = (state != CH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CH_IDLE;
      done  <= 1'b0;
    end else begin
      case (state)
        CH_IDLE: begin
          if (done_wr) done <= 1'b0;
          if (start_evt) begin
            done  <= cfg_zero;
            state <= cfg_zero ? CH_IDLE : CH_RUN;
          end
        end
        CH_RUN, CH_HOLD: begin
          if (done_wr) begin
            state <= CH_IDLE;
            done  <= 1'b0;
          end else if (ack) begin
            if (nxt_zero) begin
              state <= CH_IDLE;
              done  <= 1'b1;
            end else if (state == CH_RUN && landed) begin
              state <= CH_HOLD;
            end else begin
              state <= CH_RUN;
            end
          end else begin
            state <= CH_RUN;
          end
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_throttle.sv
module dma_chan_throttle
  import dma_thr_pkg::*;
#(
  parameter int BC_W         = 24,
  parameter int XF_W         = 3,
  parameter int BW_BASE_LOG2 = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_start,
  input  logic                 ctl_ext_en,
  input  logic [BW_CODE_W-1:0] ctl_bw_code,
  input  logic                 ctl_done_wr,
  input  logic [BC_W-1:0]      cfg_count,
  input  logic                 periph_req,
  input  logic                 bus_ack,
  input  logic [XF_W-1:0]      xfer_bytes,
  output logic                 bus_req,
  output logic                 chan_busy,
  output logic                 chan_done,
  output logic [BC_W-1:0]      bcount
);

  logic start_evt, load, dec_en, nxt_zero, landed;
  logic [BC_W-1:0] cnt_nxt;

  assign start_evt = ctl_ext_en ? periph_req : ctl_start;

  dma_thr_counter #(.BC_W(BC_W), .XF_W(XF_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (cfg_count),
    .dec_en   (dec_en),
    .dec_bytes(xfer_bytes),
    .cnt      (bcount),
    .cnt_nxt  (cnt_nxt),
    .nxt_zero (nxt_zero)
  );

  dma_thr_boundary #(.BC_W(BC_W), .BASE_LOG2(BW_BASE_LOG2)) u_bnd (
    .code   (ctl_bw_code),
    .cnt_nxt(cnt_nxt),
    .landed (landed)
  );

  dma_thr_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_evt(start_evt),
    .cfg_zero (cfg_count == '0),
    .done_wr  (ctl_done_wr),
    .ack      (bus_ack),
    .nxt_zero (nxt_zero),
    .landed   (landed),
    .load     (load),
    .dec_en   (dec_en),
    .bus_req  (bus_req),
    .busy     (chan_busy),
    .done     (chan_done)
  );

  // R2
  sw_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!chan_busy && !ctl_ext_en && ctl_start && cfg_count != '0)
      |=> (bus_req && chan_busy && !chan_done));

  // R3
  ext_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!chan_busy && ctl_ext_en && !periph_req) |=> !chan_busy);

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_busy && !bus_ack) |=> $stable(bcount));

  // R5
  exhaust_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_busy && bus_ack && !ctl_done_wr && bcount <= BC_W'(xfer_bytes))
      |=> (chan_done && !chan_busy && !bus_req));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_busy && ctl_done_wr) |=> (!chan_busy && !chan_done && $stable(bcount)));

  // R8
  gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_busy && !bus_req && !bus_ack && !ctl_done_wr) |=> bus_req);

endmodule

// File: tb/test_dma_chan_throttle.sv
module test_dma_chan_throttle;

  localparam int CLK_PERIOD = 10;
  localparam int BC_W = 12;
  localparam int XF_W = 3;
  localparam int BASE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_start = 1'b0, ctl_ext_en = 1'b0, ctl_done_wr = 1'b0;
  logic [2:0] ctl_bw_code = '0;
  logic [BC_W-1:0] cfg_count = '0;
  logic periph_req = 1'b0, bus_ack = 1'b0;
  logic [XF_W-1:0] xfer_bytes = 3'd1;
  logic bus_req, chan_busy, chan_done;
  logic [BC_W-1:0] bcount;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_req = 1'b0, exp_busy = 1'b0, exp_done = 1'b0;
  int exp_cnt = 0;

  dma_chan_throttle #(.BC_W(BC_W), .XF_W(XF_W), .BW_BASE_LOG2(BASE)) i_dma_chan_throttle (
    .clk(clk), .rst(rst), .ctl_start(ctl_start), .ctl_ext_en(ctl_ext_en),
    .ctl_bw_code(ctl_bw_code), .ctl_done_wr(ctl_done_wr), .cfg_count(cfg_count),
    .periph_req(periph_req), .bus_ack(bus_ack), .xfer_bytes(xfer_bytes),
    .bus_req(bus_req), .chan_busy(chan_busy), .chan_done(chan_done), .bcount(bcount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk1(string tag, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    #1;
    chk1(tag, "bus_req", int'(bus_req), int'(exp_req));
    chk1(tag, "chan_busy", int'(chan_busy), int'(exp_busy));
    chk1(tag, "chan_done", int'(chan_done), int'(exp_done));
    chk1(tag, "bcount", int'(bcount), exp_cnt);
  endtask

  // one full transfer, bus granted whenever the request is high
  task automatic sweep(int code, int size, int n);
    int blk;
    int guard;
    blk = (code == 0) ? 0 : (1 << (BASE + code - 1));
    ctl_bw_code = 3'(code);
    xfer_bytes = XF_W'(size);
    cfg_count = BC_W'(n);
    ctl_start = 1'b1;
    exp_busy = 1'b1; exp_req = 1'b1; exp_done = 1'b0; exp_cnt = n;
    cyc("R2");
    ctl_start = 1'b0;
    guard = 0;
    while (exp_busy && guard < 5000) begin
      string tag;
      guard++;
      if (exp_req) begin
        bus_ack = 1'b1;
        exp_cnt = (exp_cnt > size) ? exp_cnt - size : 0;
        if (exp_cnt == 0) begin
          exp_busy = 1'b0; exp_req = 1'b0; exp_done = 1'b1; tag = "R5";
        end else if (code != 0 && (exp_cnt % blk) == 0) begin
          exp_req = 1'b0; tag = "R8";
        end else begin
          exp_req = 1'b1; tag = (code != 0) ? "R9" : "R7";
        end
      end else begin
        bus_ack = 1'b0;
        exp_req = 1'b1;
        tag = "R8";
      end
      cyc(tag);
    end
    bus_ack = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    cyc("R1");
    cyc("R1");
    rst = 1'b0;
    cyc("R1");

    // R7 R8 R9 sweep over all codes and sizes
    for (int code = 0; code < 8; code++) begin
      for (int si = 0; si < 3; si++) begin
        for (int off = 3; off < 5; off++) begin
          int blk;
          blk = (code == 0) ? 8 : (1 << (BASE + code - 1));
          sweep(code, 1 << si, 2 * blk + off);
        end
      end
    end

    // R3 start bit ignored with external requests enabled
    ctl_ext_en = 1'b1; ctl_bw_code = 3'd0; cfg_count = 12'd9; xfer_bytes = 3'd1;
    ctl_start = 1'b1;
    cyc("R3");
    ctl_start = 1'b0;
    cyc("R3");
    periph_req = 1'b1;
    exp_busy = 1'b1; exp_req = 1'b1; exp_done = 1'b0; exp_cnt = 9;
    cyc("R3");
    periph_req = 1'b0; ctl_ext_en = 1'b0;

    // R4 one transfer then R6 stop
    bus_ack = 1'b1; exp_cnt = 8;
    cyc("R4");
    bus_ack = 1'b0; ctl_done_wr = 1'b1;
    exp_busy = 1'b0; exp_req = 1'b0; exp_done = 1'b0;
    cyc("R6");
    ctl_done_wr = 1'b0;
    cyc("R6");

    // R4 hold without ack, R11 start while busy
    cfg_count = 12'd10; ctl_start = 1'b1;
    exp_busy = 1'b1; exp_req = 1'b1; exp_cnt = 10;
    cyc("R2");
    ctl_start = 1'b0;
    cyc("R4");
    cyc("R4");
    cfg_count = 12'd50; ctl_start = 1'b1;
    cyc("R11");
    ctl_start = 1'b0; periph_req = 1'b1; ctl_ext_en = 1'b1;
    cyc("R11");
    periph_req = 1'b0; ctl_ext_en = 1'b0;

    // R10 code switched mid-run
    bus_ack = 1'b1; exp_cnt = 9;
    cyc("R4");
    ctl_bw_code = 3'd1; exp_cnt = 8; exp_req = 1'b0;
    cyc("R10");
    bus_ack = 1'b0; exp_req = 1'b1;
    cyc("R8");
    ctl_bw_code = 3'd0; bus_ack = 1'b1;
    for (int k = 7; k >= 4; k--) begin
      exp_cnt = k;
      cyc("R10");
    end
    bus_ack = 1'b0; ctl_done_wr = 1'b1;
    exp_busy = 1'b0; exp_req = 1'b0;
    cyc("R6");
    ctl_done_wr = 1'b0;

    // R4 R5 saturation when transfer exceeds remaining count
    cfg_count = 12'd3; xfer_bytes = 3'd4; ctl_start = 1'b1; ctl_bw_code = 3'd1;
    exp_busy = 1'b1; exp_req = 1'b1; exp_cnt = 3;
    cyc("R2");
    ctl_start = 1'b0; bus_ack = 1'b1;
    exp_busy = 1'b0; exp_req = 1'b0; exp_done = 1'b1; exp_cnt = 0;
    cyc("R5");
    bus_ack = 1'b0;
    cyc("R4");

    summary();
    $finish;
  end

endmodule